// File: doc/BRIEF.md
# Dual-Width Condition Code Generator

This block produces condition flags for a 64-bit integer datapath. It takes the two source operands, the result from the execution unit, the stored carry bit and an operation class. From these it derives two flag nibbles at once. One nibble judges the low 32-bit word and the other judges the full 64-bit word. Branch and conditional-move logic can then test either width without running the operation a second time.

The block is purely combinational. The adder, the divider and the flag register sit outside it. The execution unit also supplies a divide-overflow indication, which the 32-bit nibble reports after a divide. A write enable tells the flag register whether the current operation class updates condition codes at all.

Top module: `ccg_flag_gen`

## Requirements
- R1: Each nibble is laid out as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. In the narrow nibble (`flags_lo`), Z is set when result bits 31:0 are all zero. In the wide nibble (`flags_full`), Z is set only when all 64 result bits are zero.
- R2: N is result bit 31 in the narrow nibble and result bit 63 in the wide nibble.
- R3: For op_class 0 (add) and 1 (add with carry), C is set when the result is unsigned-less than operand A at the width of the nibble.
- R4: For op_class 0 and 1, V is set when A and B have equal sign bits and the result's sign bit differs from A's. The sign bit is bit 31 for the narrow nibble and bit 63 for the wide one.
- R5: For op_class 2 (subtract) and 3 (subtract with borrow), V is set when A and B have different sign bits and the result's sign bit differs from A's, at each width.
- R6: For op_class 2 and 3, C signals a borrow: A is unsigned-less than B plus the borrow-in, at each width. The borrow-in is `carry_in` for op_class 3 and zero for op_class 2. `carry_in` has no effect on any other class.
- R7: For op_class 4 (logical), both nibbles carry Z and N from the result, with V and C cleared.
- R8: For op_class 5 (divide), the narrow nibble takes Z and N from the result, V from `div_ovf`, and clears C. The wide nibble takes only Z and N from the result and clears V and C. `div_ovf` has no effect on any other class.
- R9: `flag_we` is 1 for op_class 0 to 5. It is 0 for op_class 6 and 7, and in that case both nibbles are driven to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 3 | Operation class, encoded as in R9 |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| result | input | 64 | Result produced by the execution unit |
| carry_in | input | 1 | Stored C bit of the narrow flag set |
| div_ovf | input | 1 | Overflow indication from the divider |
| flags_lo | output | 4 | Flag nibble for the low 32-bit word |
| flags_full | output | 4 | Flag nibble for the full 64-bit word |
| flag_we | output | 1 | Flag register write enable |

## Verification
The bench builds the block with its default parameters: a 64-bit word and a 32-bit narrow lane. With this split, many cases make the two nibbles disagree:
- a carry out of bit 31 that does not reach bit 63;
- a narrow-lane overflow that the full word does not see;
- a low word of zero under non-zero upper bits.

Directed cases target each of these, and a pseudo-random operand sweep covers every class. The bench compares both nibbles against a model built from the requirements.

// File: rtl/ccg_pkg.sv
// Shared types for the dual-width condition code generator.
// Assumes a 3-bit operation class; codes 6 and 7 never write flags.
package ccg_pkg;

    typedef enum logic [2:0] {
        OPC_ADD   = 3'd0,
        OPC_ADDC  = 3'd1,
        OPC_SUB   = 3'd2,
        OPC_SUBB  = 3'd3,
        OPC_LOGIC = 3'd4,
        OPC_DIV   = 3'd5,
        OPC_RSV6  = 3'd6,
        OPC_RSV7  = 3'd7
    } op_class_e;

    // Flag nibble: bit 3 N, bit 2 Z, bit 1 V, bit 0 C
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_nibble_t;

endpackage

// File: rtl/ccg_class_decode.sv
// Decodes the operation class into one-hot-ish control lines for the lanes.
// Assumes op_class is stable for the whole evaluation; purely combinational.
module ccg_class_decode
    import ccg_pkg::*;
(
    input  logic [2:0] op_class,
    output logic       is_add,
    output logic       is_sub,
    output logic       use_borrow,
    output logic       is_logic,
    output logic       is_div,
    output logic       write_en
);

    // Map each class code to its control lines.
    always_comb begin
        is_add     = 1'b0;
        is_sub     = 1'b0;
        use_borrow = 1'b0;
        is_logic   = 1'b0;
        is_div     = 1'b0;
        write_en   = 1'b1;
        case (op_class_e'(op_class))
            OPC_ADD, OPC_ADDC: is_add = 1'b1;
            OPC_SUB:           is_sub = 1'b1;
            OPC_SUBB: begin
                is_sub     = 1'b1;
                use_borrow = 1'b1;
            end
            OPC_LOGIC:         is_logic = 1'b1;
            OPC_DIV:           is_div = 1'b1;
            default:           write_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/ccg_lane.sv
// Computes one N/Z/V/C nibble over the low W bits of the operands and result.
// DIV_V selects whether this lane reports divide overflow in V.
// Assumes at most one of the class controls is high at a time.
module ccg_lane
    import ccg_pkg::*;
#(
    parameter int W     = 32,
    parameter bit DIV_V = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic         borrow_in,
    input  logic         div_ovf,
    input  logic         is_add,
    input  logic         is_sub,
    input  logic         use_borrow,
    input  logic         is_logic,
    input  logic         is_div,
    output cc_nibble_t   flags
);

    localparam int EW = W + 1;

    logic          sa, sb, sr;
    logic          add_c, add_v, sub_c, sub_v;
    logic [EW-1:0] sub_rhs;

    // Sign bits and the carry, borrow and overflow candidates.
    always_comb begin
        sa      = a[W-1];
        sb      = b[W-1];
        sr      = r[W-1];
        add_c   = (r < a);
        add_v   = (sa == sb) && (sr != sa);
        sub_rhs = {1'b0, b} + EW'(use_borrow & borrow_in);
        sub_c   = ({1'b0, a} < sub_rhs);
        sub_v   = (sa != sb) && (sr != sa);
    end

    // Select the nibble for the active class.
    always_comb begin
        flags   = '0;
        flags.n = sr;
        flags.z = (r == '0);
        if (is_add) begin
            flags.c = add_c;
            flags.v = add_v;
        end else if (is_sub) begin
            flags.c = sub_c;
            flags.v = sub_v;
        end else if (is_div) begin
            flags.v = DIV_V & div_ovf;
        end else if (!is_logic) begin
            flags = '0;
        end
    end

endmodule

// File: rtl/ccg_flag_gen.sv
// Dual-width condition code generator: one 64-bit operation yields a narrow
// (low word) and a wide (full word) flag nibble plus a flag write enable.
// Assumes the result is already computed; the block holds no state.
module ccg_flag_gen
    import ccg_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int LOW_W  = 32
) (
    input  logic [2:0]        op_class,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic [WORD_W-1:0] result,
    input  logic              carry_in,
    input  logic              div_ovf,
    output logic [3:0]        flags_lo,
    output logic [3:0]        flags_full,
    output logic              flag_we
);

    localparam int LANES = 2;

    logic       is_add, is_sub, use_borrow, is_logic, is_div, write_en;
    cc_nibble_t lane_flags [LANES];

    ccg_class_decode u_dec (
        .op_class   (op_class),
        .is_add     (is_add),
        .is_sub     (is_sub),
        .use_borrow (use_borrow),
        .is_logic   (is_logic),
        .is_div     (is_div),
        .write_en   (write_en)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? LOW_W : WORD_W;
        ccg_lane #(
            .W     (LW),
            .DIV_V (g == 0)
        ) u_lane (
            .a          (src_a[LW-1:0]),
            .b          (src_b[LW-1:0]),
            .r          (result[LW-1:0]),
            .borrow_in  (carry_in),
            .div_ovf    (div_ovf),
            .is_add     (is_add),
            .is_sub     (is_sub),
            .use_borrow (use_borrow),
            .is_logic   (is_logic),
            .is_div     (is_div),
            .flags      (lane_flags[g])
        );
    end

    // Gate both nibbles with the write enable.
    always_comb begin
        flag_we    = write_en;
        flags_lo   = write_en ? lane_flags[0] : 4'h0;
        flags_full = write_en ? lane_flags[1] : 4'h0;
    end

endmodule

// File: rtl/ccg_flag_gen_chk.sv
// Assertion checker for ccg_flag_gen; relates ports only. Immediate
// assertions, since the block is combinational and has no clock.
module ccg_flag_gen_chk #(
    parameter int WORD_W = 64,
    parameter int LOW_W  = 32
) (
    input logic [2:0]        op_class,
    input logic [WORD_W-1:0] result,
    input logic              div_ovf,
    input logic [3:0]        flags_lo,
    input logic [3:0]        flags_full,
    input logic              flag_we
);

    // Check port relations on every input change.
    always_comb begin
        // R1: a zero full word implies a zero low word
        a_r1_zero_nest: assert (!(flag_we && flags_full[2]) || flags_lo[2]);
        // R2: N follows the sign bits of each width
        a_r2_sign: assert (!flag_we ||
            (flags_lo[3] == result[LOW_W-1] && flags_full[3] == result[WORD_W-1]));
        // R7: logical class clears V and C
        a_r7_logic_clear: assert (op_class != 3'd4 ||
            (flags_lo[1:0] == 2'b00 && flags_full[1:0] == 2'b00));
        // R8: divide class keeps the wide V/C clear, narrow V mirrors div_ovf
        a_r8_div_flags: assert (op_class != 3'd5 ||
            (flags_full[1:0] == 2'b00 && flags_lo[0] == 1'b0 && flags_lo[1] == div_ovf));
        // R9: without a write both nibbles are zero
        a_r9_quiet: assert (flag_we || (flags_lo == 4'h0 && flags_full == 4'h0));
    end

endmodule

bind ccg_flag_gen ccg_flag_gen_chk #(
    .WORD_W (WORD_W),
    .LOW_W  (LOW_W)
) u_chk (
    .op_class   (op_class),
    .result     (result),
    .div_ovf    (div_ovf),
    .flags_lo   (flags_lo),
    .flags_full (flags_full),
    .flag_we    (flag_we)
);

// File: tb/ccg_flag_gen_test.sv
// Directed bench for ccg_flag_gen: one task per scenario, each checking itself.
module ccg_flag_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_class = 3'd6;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] result = '0;
    logic        carry_in = 1'b0;
    logic        div_ovf = 1'b0;
    logic [3:0]  flags_lo, flags_full;
    logic        flag_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ccg_flag_gen uut (
        .op_class   (op_class),
        .src_a      (src_a),
        .src_b      (src_b),
        .result     (result),
        .carry_in   (carry_in),
        .div_ovf    (div_ovf),
        .flags_lo   (flags_lo),
        .flags_full (flags_full),
        .flag_we    (flag_we)
    );

    // Reference nibble {N,Z,V,C} per the requirements, at width w.
    function automatic logic [3:0] model(input int w, input logic [2:0] op,
                                         input logic [63:0] a, input logic [63:0] b,
                                         input logic [63:0] r, input logic cin,
                                         input logic dovf);
        logic [64:0] mask, am, bm, rm;
        logic n, z, v, c, sa, sb, sr;
        mask = (65'd1 << w) - 65'd1;
        am = {1'b0, a} & mask;
        bm = {1'b0, b} & mask;
        rm = {1'b0, r} & mask;
        sa = am[w-1]; sb = bm[w-1]; sr = rm[w-1];
        n = sr; z = (rm == 65'd0); v = 1'b0; c = 1'b0;
        case (op)
            3'd0, 3'd1: begin c = rm < am; v = (sa == sb) && (sr != sa); end
            3'd2:       begin c = am < bm; v = (sa != sb) && (sr != sa); end
            3'd3:       begin c = am < (bm + {64'd0, cin}); v = (sa != sb) && (sr != sa); end
            3'd4:       ;
            3'd5:       v = (w == 32) ? dovf : 1'b0;
            default:    begin n = 1'b0; z = 1'b0; end
        endcase
        return {n, z, v, c};
    endfunction

    task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got we=%b lo=%h full=%h, expected we=%b lo=%h full=%h",
                     req, got[8], got[7:4], got[3:0], exp[8], exp[7:4], exp[3:0]);
        end
    endtask

    // Drive one operation at the falling edge, sample 1 ns later, compare to model.
    task automatic apply(input string req, input logic [2:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] r,
                         input logic cin, input logic dovf);
        logic [8:0] exp;
        @(negedge clk);
        op_class = op; src_a = a; src_b = b; result = r; carry_in = cin; div_ovf = dovf;
        #1;
        exp = {(op <= 3'd5), model(32, op, a, b, r, cin, dovf), model(64, op, a, b, r, cin, dovf)};
        check(req, {flag_we, flags_lo, flags_full}, exp);
    endtask

    task automatic t_idle();
        @(negedge clk); #1;
        check("R9 idle state", {flag_we, flags_lo, flags_full}, 9'h000);
        apply("R9 class 7 no write", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b1, 1'b1);
        check("R9 class 7 literal", {flag_we, flags_lo, flags_full}, 9'h000);
    endtask

    task automatic t_add();
        // R1 R3: carry out of bit 31 only, low word zero
        apply("R1 R3 add low carry", 3'd0, 64'h0000_0000_FFFF_FFFF, 64'd1,
              64'h0000_0001_0000_0000, 1'b0, 1'b0);
        check("R1 R3 add literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b0101, 4'b0000});
        // R2 R4: narrow overflow only
        apply("R2 R4 add narrow ovf", 3'd0, 64'h0000_0000_7FFF_FFFF, 64'd1,
              64'h0000_0000_8000_0000, 1'b0, 1'b0);
        check("R2 R4 add literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b1010, 4'b0000});
        // R4: wide overflow
        apply("R4 add wide ovf", 3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1,
              64'h8000_0000_0000_0000, 1'b0, 1'b0);
        // R3: add with carry, full wrap
        apply("R3 addc wrap", 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 1'b1, 1'b0);
        check("R1 R3 addc literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b0101, 4'b0101});
    endtask

    task automatic t_sub();
        apply("R6 sub borrow", 3'd2, 64'd1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        check("R6 sub literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b1001, 4'b1001});
        apply("R6 sub ignores carry_in", 3'd2, 64'd5, 64'd5, 64'd0, 1'b1, 1'b0);
        check("R6 sub cin literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b0100, 4'b0100});
        apply("R6 subb uses carry_in", 3'd3, 64'd5, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
        check("R6 subb literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b1001, 4'b1001});
        apply("R5 sub narrow ovf", 3'd2, 64'h0000_0000_8000_0000, 64'd1,
              64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0);
        check("R5 sub literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b0010, 4'b0000});
    endtask

    task automatic t_logic_div();
        apply("R7 logic upper only", 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1,
              64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1);
        check("R7 logic literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b0100, 4'b1000});
        apply("R8 div overflow", 3'd5, 64'd7, 64'd3, 64'h0000_0000_8000_0000, 1'b1, 1'b1);
        check("R8 div literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b1010, 4'b0000});
        apply("R8 div zero result", 3'd5, 64'd0, 64'd3, 64'd0, 1'b0, 1'b0);
        apply("R8 div_ovf ignored by add", 3'd0, 64'd1, 64'd1, 64'd2, 1'b0, 1'b1);
        check("R8 div_ovf add literal", {flag_we, flags_lo, flags_full}, {1'b1, 4'b0000, 4'b0000});
    endtask

    // Pseudo-random sweep over all classes, results formed as the datapath would.
    task automatic t_sweep();
        logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
        logic [63:0] a, b, r;
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            logic       cin;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            a = s;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            b = (i % 5 == 0) ? {32'h0, s[31:0]} : s;
            op  = 3'(i % 8);
            cin = s[40];
            case (op)
                3'd0: r = a + b;
                3'd1: r = a + b + 64'(cin);
                3'd2: r = a - b;
                3'd3: r = a - b - 64'(cin);
                3'd4: r = a & b;
                default: r = a ^ b;
            endcase
            apply("R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep", op, a, b, r, cin, s[50]);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_add();
        t_sub();
        t_logic_div();
        t_sweep();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule